// File: doc/BRIEF.md
# Power-On and System Reset Sequencer

This block produces every reset-related output of a small system-on-chip from a single active-low power-on input, a watchdog reset event and a software reset request. While power-on reset is active, it captures the configuration strap inputs and holds all clock generators off. It also clears the timer control bits and keeps the peripheral bus and the CPU in reset.

Once power-on reset is released through a two-flop synchronizer, the clock generators turn their outputs on one after another. Each generator may switch on only after it reports lock and after its lower-numbered neighbour is already on, so the highest-numbered generator is always the last to start. The CPU reset then stays asserted for a programmable number of clocks, which stands in for a delay of roughly one hundred microseconds. Watchdog and software resets act only on the peripheral bus reset. They hold it low for a programmable minimum width and leave the straps, the generators and the CPU untouched.

Top module: `reset_sequencer`

## Requirements
- R1: While `pwron_rst_n` is low, `gen_out_en` is all zeros, `cpu_rst` is 1 and `bus_rst_n` is 0, whatever the values on `gen_lock`. These outputs take their reset values without waiting for a clock edge.
- R2: `strap_q` loads `strap_in` on every rising clock edge while the internal power-on reset is active, and it holds the last value captured for as long as that reset stays released. `strap_strobe` is high for exactly one clock, in the cycle that begins at the second rising edge after `pwron_rst_n` goes high.
- R3: The internal power-on reset ends at the second rising clock edge after `pwron_rst_n` goes high, and `bus_rst_n` goes high at that same edge.
- R4: Bit i of `gen_out_en` rises at the first rising edge at which two conditions hold: `gen_lock[i]` is high and bit i-1 is already high (bit 0 needs only its lock). A bit never rises while internal reset is active. Once set, a bit stays high until the next power-on reset. The highest bit is therefore the last to rise.
- R5: `cpu_rst` falls exactly CPU_HOLD clocks after the highest bit of `gen_out_en` rises, and it stays high until then.
- R6: When `wdt_rst_evt` or `sw_rst_req` is sampled high at a rising edge, `bus_rst_n` is low from that edge on. It returns high BUS_PW clocks after the last edge at which a request was sampled.
- R7: Watchdog and software requests have no effect on `strap_q`, `strap_strobe`, `gen_out_en`, `cpu_rst` or `tmr_clr`.
- R8: `tmr_clr` is high exactly while the internal power-on reset is active. That is, it goes high as soon as `pwron_rst_n` falls and goes low at the second rising edge after `pwron_rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| pwron_rst_n | input | 1 | Power-on reset, active low, asynchronous assertion |
| wdt_rst_evt | input | 1 | Watchdog reset event, active high |
| sw_rst_req | input | 1 | Software reset request, active high |
| strap_in | input | STRAP_W | Configuration strap inputs |
| gen_lock | input | NUM_GEN | Lock indication from each clock generator |
| strap_q | output | STRAP_W | Captured strap values |
| strap_strobe | output | 1 | One-clock pulse marking that `strap_q` is final |
| gen_out_en | output | NUM_GEN | Output enable for each clock generator |
| bus_rst_n | output | 1 | Peripheral bus reset, active low |
| cpu_rst | output | 1 | CPU reset, active high |
| tmr_clr | output | 1 | Clear for watchdog and high-resolution timer control bits |

## Verification
The in-line assertions check, on every cycle outside reset, that the enables only rise in index order, only after a lock and never fall. They also check that the CPU stays in reset while any generator is off, that a sampled request pulls the bus reset low on the next cycle, and that the straps and the strobe stay frozen. Only the bench's scenarios can show the exact release cycles: the two-edge synchronizer latency, the exact CPU_HOLD and BUS_PW counts, and the way locks that arrive in every order stretch the enable staircase. The bench computes each of these arithmetically for all sixteen strap patterns and all six lock-arrival orders.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        CPU_WAIT_CLK = 2'd0,
        CPU_COUNT    = 2'd1,
        CPU_RELEASED = 2'd2
    } cpu_phase_e;

    typedef struct packed {
        logic wdt;
        logic sw;
    } soft_req_t;

    function automatic logic soft_any(input soft_req_t r);
        return r.wdt | r.sw;
    endfunction

endpackage

// File: rtl/rstseq_por_front.sv
module rstseq_por_front #(
    parameter int STRAP_W = 4
) (
    input  logic               clk,
    input  logic               pwron_rst_n,
    input  logic [STRAP_W-1:0] strap_in,
    output logic               rst_o,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_strobe
);
    logic sync1_q;
    logic sync2_q;
    logic rst_d;

    // assert asynchronously, release through two flops
    always_ff @(posedge clk or negedge pwron_rst_n) begin
        if (!pwron_rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= 1'b1;
            sync2_q <= sync1_q;
        end
    end

    assign rst_o = ~sync2_q;

    always_ff @(posedge clk) begin
        rst_d <= rst_o;
        if (rst_o) strap_q <= strap_in;
    end

    assign strap_strobe = rst_d & ~rst_o;

    // R2
    strap_hold_chk: assert property (@(posedge clk) disable iff (rst_o)
        !rst_o |=> $stable(strap_q));

    // R2
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst_o)
        strap_strobe |=> !strap_strobe);

endmodule

// File: rtl/rstseq_gen_chain.sv
module rstseq_gen_chain #(
    parameter int NUM_GEN = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_GEN-1:0] lock,
    output logic [NUM_GEN-1:0] en_q,
    output logic               all_en
);
    for (genvar i = 0; i < NUM_GEN; i++) begin : g_stage
        logic prev_on;
        if (i == 0) begin : g_first
            assign prev_on = 1'b1;
        end else begin : g_next
            assign prev_on = en_q[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) en_q[i] <= 1'b0;
            else if (prev_on && lock[i]) en_q[i] <= 1'b1;
        end

        // R4
        gen_lock_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(en_q[i]) |-> $past(lock[i]));

        // R4
        gen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            en_q[i] |=> en_q[i]);

        if (i > 0) begin : g_ord
            // R4
            gen_order_chk: assert property (@(posedge clk) disable iff (rst)
                en_q[i] |-> en_q[i-1]);
        end
    end

    assign all_en = en_q[NUM_GEN-1];

endmodule

// File: rtl/rstseq_cpu_hold.sv
module rstseq_cpu_hold
    import rstseq_pkg::*;
#(
    parameter int CPU_HOLD = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic all_en,
    output logic cpu_rst
);
    localparam int CW = $clog2(CPU_HOLD + 1);

    cpu_phase_e    phase_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= CPU_WAIT_CLK;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                CPU_WAIT_CLK: if (all_en) begin
                    cnt_q   <= CW'(1);
                    phase_q <= (CPU_HOLD <= 1) ? CPU_RELEASED : CPU_COUNT;
                end
                CPU_COUNT: begin
                    if (cnt_q == CW'(CPU_HOLD - 1)) phase_q <= CPU_RELEASED;
                    else cnt_q <= cnt_q + CW'(1);
                end
                default: phase_q <= CPU_RELEASED;
            endcase
        end
    end

    assign cpu_rst = rst | (phase_q != CPU_RELEASED);

    // R5
    cpu_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !all_en |-> cpu_rst);

    // R5
    cpu_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(CPU_HOLD));

endmodule

// File: rtl/rstseq_bus_pulse.sv
module rstseq_bus_pulse
    import rstseq_pkg::*;
#(
    parameter int BUS_PW = 64
) (
    input  logic      clk,
    input  logic      rst,
    input  soft_req_t req,
    output logic      bus_rst_n
);
    localparam int PW_W = $clog2(BUS_PW + 1);

    logic [PW_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst) left_q <= '0;
        else if (soft_any(req)) left_q <= PW_W'(BUS_PW);
        else if (left_q != '0) left_q <= left_q - PW_W'(1);
    end

    assign bus_rst_n = ~(rst | (left_q != '0));

    // R6
    bus_evt_chk: assert property (@(posedge clk) disable iff (rst)
        soft_any(req) |=> !bus_rst_n);

    // R6
    bus_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        left_q <= PW_W'(BUS_PW));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int NUM_GEN  = 3,
    parameter int STRAP_W  = 4,
    parameter int CPU_HOLD = 10000,
    parameter int BUS_PW   = 64
) (
    input  logic               clk,
    input  logic               pwron_rst_n,
    input  logic               wdt_rst_evt,
    input  logic               sw_rst_req,
    input  logic [STRAP_W-1:0] strap_in,
    input  logic [NUM_GEN-1:0] gen_lock,
    output logic [STRAP_W-1:0] strap_q,
    output logic               strap_strobe,
    output logic [NUM_GEN-1:0] gen_out_en,
    output logic               bus_rst_n,
    output logic               cpu_rst,
    output logic               tmr_clr
);
    logic               por_rst;
    logic [NUM_GEN-1:0] en_q;
    logic               all_en;
    soft_req_t          req;

    assign req.wdt = wdt_rst_evt;
    assign req.sw  = sw_rst_req;

    rstseq_por_front #(.STRAP_W(STRAP_W)) u_front (
        .clk          (clk),
        .pwron_rst_n  (pwron_rst_n),
        .strap_in     (strap_in),
        .rst_o        (por_rst),
        .strap_q      (strap_q),
        .strap_strobe (strap_strobe)
    );

    rstseq_gen_chain #(.NUM_GEN(NUM_GEN)) u_gens (
        .clk    (clk),
        .rst    (por_rst),
        .lock   (gen_lock),
        .en_q   (en_q),
        .all_en (all_en)
    );

    rstseq_cpu_hold #(.CPU_HOLD(CPU_HOLD)) u_cpu (
        .clk     (clk),
        .rst     (por_rst),
        .all_en  (all_en),
        .cpu_rst (cpu_rst)
    );

    rstseq_bus_pulse #(.BUS_PW(BUS_PW)) u_bus (
        .clk       (clk),
        .rst       (por_rst),
        .req       (req),
        .bus_rst_n (bus_rst_n)
    );

    // gating makes power-on assertion take effect without a clock
    assign gen_out_en = en_q & {NUM_GEN{~por_rst}};
    assign tmr_clr    = por_rst;

    // R7
    soft_no_cpu_chk: assert property (@(posedge clk) disable iff (por_rst)
        (!cpu_rst && soft_any(req)) |=> !cpu_rst);

endmodule

// File: tb/reset_sequencer_test.sv
module reset_sequencer_test;
    localparam int NG   = 3;
    localparam int SW   = 4;
    localparam int HOLD = 20;
    localparam int PW   = 5;

    logic          clk = 1'b0;
    logic          pwron_rst_n;
    logic          wdt_rst_evt;
    logic          sw_rst_req;
    logic [SW-1:0] strap_in;
    logic [NG-1:0] gen_lock;
    logic [SW-1:0] strap_q;
    logic          strap_strobe;
    logic [NG-1:0] gen_out_en;
    logic          bus_rst_n;
    logic          cpu_rst;
    logic          tmr_clr;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    reset_sequencer #(.NUM_GEN(NG), .STRAP_W(SW), .CPU_HOLD(HOLD), .BUS_PW(PW)) uut (
        .clk(clk), .pwron_rst_n(pwron_rst_n), .wdt_rst_evt(wdt_rst_evt),
        .sw_rst_req(sw_rst_req), .strap_in(strap_in), .gen_lock(gen_lock),
        .strap_q(strap_q), .strap_strobe(strap_strobe), .gen_out_en(gen_out_en),
        .bus_rst_n(bus_rst_n), .cpu_rst(cpu_rst), .tmr_clr(tmr_clr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic int lock_delay(input int p, input int i);
        int t [6][3] = '{'{0,3,6}, '{0,6,3}, '{3,0,6}, '{3,6,0}, '{6,0,3}, '{6,3,0}};
        return t[p][i];
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic run_seq(input int s);
        int  lk [NG];
        int  e [NG];
        int  last;
        bit  preset;
        int  h;
        bit  use_wdt;

        preset = (s % 4) == 3;
        @(negedge clk);
        pwron_rst_n = 1'b0;
        strap_in    = SW'(s);
        gen_lock    = preset ? '1 : '0;
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            // R1 reset values regardless of lock
            chk_eq("R1 gen_out_en", int'(gen_out_en), 0);
            chk_eq("R1 cpu_rst", int'(cpu_rst), 1);
            chk_eq("R1 bus_rst_n", int'(bus_rst_n), 0);
            // R8 clear during reset
            chk_eq("R8 tmr_clr", int'(tmr_clr), 1);
            // R2 capture during reset
            chk_eq("R2 strap_q capture", int'(strap_q), s);
        end
        pwron_rst_n = 1'b1;

        for (int i = 0; i < NG; i++) begin
            int le;
            le = preset ? 2 : 2 + lock_delay(s % 6, i);
            lk[i] = le;
            if (i == 0) e[i] = le + 1;
            else e[i] = ((le > e[i-1]) ? le : e[i-1]) + 1;
        end
        last = e[NG-1] + HOLD + 2;

        for (int k = 1; k <= last; k++) begin
            @(negedge clk);
            if (k == 1) begin
                // R3 still in reset after one edge
                chk_eq("R3 bus_rst_n one edge", int'(bus_rst_n), 0);
                chk_eq("R8 tmr_clr one edge", int'(tmr_clr), 1);
            end
            if (k == 2) begin
                // R3 released at second edge
                chk_eq("R3 bus_rst_n released", int'(bus_rst_n), 1);
                chk_eq("R8 tmr_clr released", int'(tmr_clr), 0);
                chk_eq("R2 strap_q final", int'(strap_q), s);
                strap_in = ~SW'(s);
            end
            // R2 strobe exactly at k==2
            chk_eq("R2 strap_strobe", int'(strap_strobe), (k == 2) ? 1 : 0);
            if (k > 2) chk_eq("R2 strap_q held", int'(strap_q), s);
            for (int i = 0; i < NG; i++) begin
                // R4 enable staircase
                chk_eq($sformatf("R4 gen_out_en[%0d] k=%0d", i, k),
                       int'(gen_out_en[i]), (k >= e[i]) ? 1 : 0);
            end
            // R5 CPU hold
            chk_eq($sformatf("R5 cpu_rst k=%0d", k), int'(cpu_rst),
                   (k < e[NG-1] + HOLD) ? 1 : 0);
            for (int i = 0; i < NG; i++)
                if (k >= lk[i]) gen_lock[i] = 1'b1;
        end

        h = ((s % 3) == 2) ? 3 : 1;
        use_wdt = (s % 2) == 0;
        for (int j = 0; j <= h + PW + 2; j++) begin
            @(negedge clk);
            // R6 pulse window
            chk_eq($sformatf("R6 bus_rst_n j=%0d", j), int'(bus_rst_n),
                   (j >= 1 && j <= h + PW - 1) ? 0 : 1);
            // R7 requests touch nothing else
            chk_eq("R7 gen_out_en", int'(gen_out_en), (1 << NG) - 1);
            chk_eq("R7 cpu_rst", int'(cpu_rst), 0);
            chk_eq("R7 strap_q", int'(strap_q), s);
            chk_eq("R7 strap_strobe", int'(strap_strobe), 0);
            chk_eq("R7 tmr_clr", int'(tmr_clr), 0);
            wdt_rst_evt = use_wdt && (j < h);
            sw_rst_req  = !use_wdt && (j < h);
        end
    endtask

    initial begin
        pwron_rst_n = 1'b1;
        wdt_rst_evt = 1'b0;
        sw_rst_req  = 1'b0;
        strap_in    = '0;
        gen_lock    = '0;
        #1 pwron_rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1 state right after power-up
        chk_eq("R1 initial cpu_rst", int'(cpu_rst), 1);
        chk_eq("R1 initial gen_out_en", int'(gen_out_en), 0);
        chk_eq("R1 initial bus_rst_n", int'(bus_rst_n), 0);
        chk_eq("R8 initial tmr_clr", int'(tmr_clr), 1);
        for (int s = 0; s < 16; s++) run_seq(s);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule